// File: doc/BRIEF.md
# LIN Master Bus Error Monitor

This block sits next to the bit-timed field sequencer of a LIN master and watches each byte field on the bus. On every bit sample point the sequencer hands it the bit it drove and the level it read back, and it frames every field with a start strobe and an end strobe. Three mode flags tell the monitor whether the master is sending the header, sending a response, or listening to a slave's response. When none of them is set, the bus counts as idle.

While the master transmits, the monitor tells two faults apart. One is an ordinary mismatch between the driven and the read-back field word. The other is a line clamped to one level, seen as no falling start edge within a programmable number of bit times. It reports which way the line is stuck through a 4-bit capture code. While the master receives, it checks only that the stop bit is recessive. Field faults are reported one cycle after the field-end strobe, together with a one-cycle abort request back to the sequencer. A dominant level on the idle bus is flagged as a wake-up at the first clock that samples it.

All inputs and outputs are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. The sequencer's strobes are taken as given on every clock.

Top module: `lin_bus_errmon`

## Requirements
- R1: While none of `hdr_tx`, `rsp_tx`, `rsp_rx` is set, `rx_bit` = 0 sampled on any clock sets `wake_err` on the next cycle, and the capture code for it is 4'b0010.
- R2: In a transmit mode (`hdr_tx` or `rsp_tx`), if the received 8 data bits (LSB first, after the start bit) or the stop bit differ from the transmitted ones, `bit_err` sets in the cycle after `field_end` and not before. The bit-error capture code is 4'b0001.
- R3: In receive mode (`rsp_rx` only), a dominant (0) stop bit sets `bit_err` after `field_end`, and data-bit differences between `tx_bit` and `rx_bit` are ignored.
- R4: In a transmit mode, if no falling edge of `rx_bit` occurs on one of the first `start_tmo` bit ticks after `field_start`, and the last sampled `rx_bit` is 1, `clamp_err` sets after `field_end` with capture code 4'b1000.
- R5: As R4, but with the last sampled `rx_bit` 0, the capture code is 4'b1001.
- R6: When one field gives both a late or missing start edge and a word mismatch, `clamp_err` and `bit_err` both set, and the code is the line-clamped one.
- R7: `abort_req` pulses for exactly the cycle after a `field_end` whose field produced a bit or line-clamped error, and is low otherwise.
- R8: Each flag stays set until its clear bit (`clr[0]` bit, `clr[1]` clamp, `clr[2]` wake) is pulsed. A new error in the same cycle as its clear keeps the flag set.
- R9: `err_code` holds the code of the first error since it was last empty. It returns to 4'b0000 when a clear leaves all three flags low.
- R10: After reset all flags, `abort_req` and `err_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| tx_bit | input | 1 | Bit the master drove for this sample point |
| rx_bit | input | 1 | Bus level read back (0 dominant) |
| field_start | input | 1 | Opens a field window; given on a cycle without `bit_tick` |
| field_end | input | 1 | Closes the field; the field is judged on this cycle |
| hdr_tx | input | 1 | Master is sending the header |
| rsp_tx | input | 1 | Master is sending the response |
| rsp_rx | input | 1 | Master is receiving a slave response |
| start_tmo | input | 4 | Start-edge window in bit ticks after `field_start` |
| clr | input | 3 | Write-one-to-clear pulses for bit, clamp, wake flags |
| bit_err | output | 1 | Sticky bit-error flag |
| clamp_err | output | 1 | Sticky line-clamped flag |
| wake_err | output | 1 | Sticky wake-up / protocol flag |
| err_code | output | 4 | Capture code of the first error |
| abort_req | output | 1 | One-cycle request to abort the frame |

## Verification
Field results (`bit_err`, `clamp_err`, `err_code`, `abort_req`) are due one cycle after the clock that samples `field_end`. The bench raises `field_end` on a falling edge and checks on the next falling edge, where the abort pulse is still high. Before raising `field_end` it checks the flags once more, so that no field error shows up early. A wake-up is due one cycle after the first dominant idle sample and is checked at the next falling edge. Clears are checked one cycle after their pulse.

// File: rtl/lin_errmon_pkg.sv
package lin_errmon_pkg;

  localparam int NFLAGS   = 3;
  localparam int FLAG_BIT = 0;
  localparam int FLAG_CLP = 1;
  localparam int FLAG_WAK = 2;

  typedef enum logic [3:0] {
    CODE_NONE      = 4'b0000,
    CODE_BIT       = 4'b0001,
    CODE_WAKE      = 4'b0010,
    CODE_STUCK_REC = 4'b1000,
    CODE_STUCK_DOM = 4'b1001
  } err_code_e;

  typedef struct packed {
    logic bit_ev;
    logic clamp_ev;
    logic level;
  } fld_verdict_t;

endpackage

// File: rtl/lin_fld_capture.sv
module lin_fld_capture #(
  parameter int DATA_BITS = 8,
  parameter int TMO_W     = 4,
  localparam int W        = DATA_BITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             field_start,
  input  logic [TMO_W-1:0] start_tmo,
  output logic             start_ok,
  output logic             started,
  output logic             done,
  output logic [W-1:0]     tx_word,
  output logic [W-1:0]     rx_word,
  output logic             rx_level
);

  localparam int IW = $clog2(W + 2);
  localparam logic [IW-1:0] IDX_LAST = IW'(W);
  localparam logic [IW-1:0] IDX_DONE = IW'(W + 1);

  logic             rx_prev;
  logic [IW-1:0]    idx;
  logic [TMO_W-1:0] wcnt;
  logic             fall;

  assign fall = bit_tick && rx_prev && !rx_bit;

  // last sampled line level, followed on every bit tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_prev <= 1'b1;
    else if (bit_tick) rx_prev <= rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      wcnt     <= '0;
      start_ok <= 1'b0;
      started  <= 1'b0;
      tx_word  <= '0;
      rx_word  <= '0;
    end else if (field_start) begin
      idx      <= '0;
      wcnt     <= '0;
      start_ok <= 1'b0;
      started  <= 1'b0;
      tx_word  <= '0;
      rx_word  <= '0;
    end else if (bit_tick) begin
      if (!started) begin
        if (fall) begin
          started <= 1'b1;
          idx     <= IW'(1);
          if (wcnt < start_tmo) start_ok <= 1'b1;
        end
        if (wcnt != '1) wcnt <= wcnt + 1'b1;
      end else if (idx <= IDX_LAST) begin
        tx_word <= {tx_bit, tx_word[W-1:1]};
        rx_word <= {rx_bit, rx_word[W-1:1]};
        idx     <= idx + 1'b1;
      end
    end
  end

  assign done     = started && (idx == IDX_DONE);
  assign rx_level = rx_prev;

endmodule

// File: rtl/lin_fld_judge.sv
module lin_fld_judge
  import lin_errmon_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int W        = DATA_BITS + 1
) (
  input  logic         hdr_tx,
  input  logic         rsp_tx,
  input  logic         rsp_rx,
  input  logic         start_ok,
  input  logic         started,
  input  logic         done,
  input  logic [W-1:0] tx_word,
  input  logic [W-1:0] rx_word,
  input  logic         rx_level,
  output fld_verdict_t verdict
);

  logic tx_act;
  logic mismatch;
  logic stop_dom;

  assign tx_act   = hdr_tx | rsp_tx;
  assign mismatch = started && (tx_word != rx_word);
  assign stop_dom = done && !rx_word[W-1];

  always_comb begin
    verdict.clamp_ev = tx_act && !start_ok;
    verdict.level    = rx_level;
    if (tx_act)      verdict.bit_ev = mismatch;
    else if (rsp_rx) verdict.bit_ev = stop_dom;
    else             verdict.bit_ev = 1'b0;
  end

endmodule

// File: rtl/lin_err_latch.sv
module lin_err_latch
  import lin_errmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_end,
  input  fld_verdict_t      verdict,
  input  logic              wake_ev,
  input  logic [NFLAGS-1:0] clr,
  output logic [NFLAGS-1:0] flags,
  output logic [3:0]        code,
  output logic              abort
);

  logic [NFLAGS-1:0] set_v;
  logic [NFLAGS-1:0] kept;
  logic [NFLAGS-1:0] flags_nxt;
  err_code_e         new_code;
  logic [3:0]        base_code;

  assign set_v[FLAG_BIT] = field_end & verdict.bit_ev;
  assign set_v[FLAG_CLP] = field_end & verdict.clamp_ev;
  assign set_v[FLAG_WAK] = wake_ev;
  assign kept            = flags & ~clr;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    assign flags_nxt[g] = kept[g] | set_v[g];
  end

  always_comb begin
    if (set_v[FLAG_CLP])      new_code = verdict.level ? CODE_STUCK_REC : CODE_STUCK_DOM;
    else if (set_v[FLAG_BIT]) new_code = CODE_BIT;
    else if (set_v[FLAG_WAK]) new_code = CODE_WAKE;
    else                      new_code = CODE_NONE;
  end

  assign base_code = (kept != '0) ? code : CODE_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      code  <= CODE_NONE;
      abort <= 1'b0;
    end else begin
      flags <= flags_nxt;
      code  <= (base_code == CODE_NONE) ? new_code : base_code;
      abort <= set_v[FLAG_BIT] | set_v[FLAG_CLP];
    end
  end

endmodule

// File: rtl/lin_bus_errmon.sv
module lin_bus_errmon
  import lin_errmon_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int TMO_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_bit,
  input  logic             rx_bit,
  input  logic             field_start,
  input  logic             field_end,
  input  logic             hdr_tx,
  input  logic             rsp_tx,
  input  logic             rsp_rx,
  input  logic [TMO_W-1:0] start_tmo,
  input  logic [2:0]       clr,
  output logic             bit_err,
  output logic             clamp_err,
  output logic             wake_err,
  output logic [3:0]       err_code,
  output logic             abort_req
);

  localparam int W = DATA_BITS + 1;

  logic         start_ok, started, done, rx_level;
  logic [W-1:0] tx_word, rx_word;
  fld_verdict_t verdict;
  logic         bus_idle;
  logic [NFLAGS-1:0] flags;

  assign bus_idle = !(hdr_tx | rsp_tx | rsp_rx);

  lin_fld_capture #(.DATA_BITS(DATA_BITS), .TMO_W(TMO_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .field_start(field_start),
    .start_tmo  (start_tmo),
    .start_ok   (start_ok),
    .started    (started),
    .done       (done),
    .tx_word    (tx_word),
    .rx_word    (rx_word),
    .rx_level   (rx_level)
  );

  lin_fld_judge #(.DATA_BITS(DATA_BITS)) u_judge (
    .hdr_tx  (hdr_tx),
    .rsp_tx  (rsp_tx),
    .rsp_rx  (rsp_rx),
    .start_ok(start_ok),
    .started (started),
    .done    (done),
    .tx_word (tx_word),
    .rx_word (rx_word),
    .rx_level(rx_level),
    .verdict (verdict)
  );

  lin_err_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .field_end(field_end),
    .verdict  (verdict),
    .wake_ev  (bus_idle && !rx_bit),
    .clr      (clr),
    .flags    (flags),
    .code     (err_code),
    .abort    (abort_req)
  );

  assign bit_err   = flags[FLAG_BIT];
  assign clamp_err = flags[FLAG_CLP];
  assign wake_err  = flags[FLAG_WAK];

endmodule

// File: rtl/lin_bus_errmon_chk.sv
module lin_bus_errmon_chk #(
  parameter int TMO_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_bit,
  input logic             field_end,
  input logic             hdr_tx,
  input logic             rsp_tx,
  input logic             rsp_rx,
  input logic [TMO_W-1:0] start_tmo,
  input logic [2:0]       clr,
  input logic             bit_err,
  input logic             clamp_err,
  input logic             wake_err,
  input logic [3:0]       err_code,
  input logic             abort_req
);

  // R7
  abort_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $past(field_end));

  // R2
  bit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err) |-> $past(field_end));

  // R1
  wake_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hdr_tx | rsp_tx | rsp_rx) && !rx_bit) |=> wake_err);

  // R8
  bit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bit_err) |-> $past(clr[0]));

  // R8
  clamp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_err) |-> $past(clr[1]));

  // R8
  wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_err) |-> $past(clr[2]));

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 4'b0000 && clr == 3'b000) |=> $stable(err_code));

  // R4
  clamp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clamp_err) && $past(err_code) == 4'b0000) |-> (err_code[3:1] == 3'b100));

endmodule

bind lin_bus_errmon lin_bus_errmon_chk #(.TMO_W(TMO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_bit   (rx_bit),
  .field_end(field_end),
  .hdr_tx   (hdr_tx),
  .rsp_tx   (rsp_tx),
  .rsp_rx   (rsp_rx),
  .start_tmo(start_tmo),
  .clr      (clr),
  .bit_err  (bit_err),
  .clamp_err(clamp_err),
  .wake_err (wake_err),
  .err_code (err_code),
  .abort_req(abort_req)
);

// File: tb/lin_bus_errmon_bench.sv
module lin_bus_errmon_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, tx_bit = 1'b1, rx_bit = 1'b1;
  logic field_start = 1'b0, field_end = 1'b0;
  logic hdr_tx = 1'b0, rsp_tx = 1'b0, rsp_rx = 1'b0;
  logic [3:0] start_tmo = 4'd2;
  logic [2:0] clr = 3'b000;
  logic bit_err, clamp_err, wake_err, abort_req;
  logic [3:0] err_code;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic finished = 1'b0;

  logic [2:0] m_flags = 3'b000;
  logic [3:0] m_code = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_bus_errmon u_lin_bus_errmon (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .field_start(field_start), .field_end(field_end), .hdr_tx(hdr_tx), .rsp_tx(rsp_tx),
    .rsp_rx(rsp_rx), .start_tmo(start_tmo), .clr(clr), .bit_err(bit_err),
    .clamp_err(clamp_err), .wake_err(wake_err), .err_code(err_code), .abort_req(abort_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<60000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_for(input logic clamp, input logic bad, input logic lvl);
    if (clamp) return lvl ? 4'b1000 : 4'b1001;
    if (bad)   return 4'b0001;
    return 4'b0000;
  endfunction

  // model of sticky flags and first-error code (R8, R9)
  task automatic model_apply(input logic [2:0] set_v, input logic [2:0] mask, input logic [3:0] newc);
    logic [2:0] kept;
    logic [3:0] base;
    kept = m_flags & ~mask;
    base = (kept != 3'b000) ? m_code : 4'b0000;
    m_flags = kept | set_v;
    m_code = (base == 4'b0000) ? newc : base;
  endtask

  task automatic tick(input logic t, input logic r);
    bit_tick = 1'b1; tx_bit = t; rx_bit = r;
    @(negedge clk);
    bit_tick = 1'b0;
    @(negedge clk);
  endtask

  // mode: 0 header tx, 1 response tx, 2 response rx
  // stuck: 0 normal, 1 rx held recessive, 2 rx held dominant
  task automatic do_field(input int mode, input logic [7:0] txb, input logic [7:0] rxb,
                          input logic rxstop, input int delay, input int stuck,
                          input logic [2:0] clr_m, input string req);
    logic lvl, tx_act, started, in_win, clamp, bad, lvl_end;
    lvl = (stuck == 2) ? 1'b0 : 1'b1;
    @(negedge clk);
    hdr_tx = (mode == 0); rsp_tx = (mode == 1); rsp_rx = (mode == 2);
    rx_bit = lvl; tx_bit = 1'b1;
    tick(1'b1, lvl);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    for (int i = 0; i < delay; i++) tick(1'b1, lvl);
    if (stuck == 0) begin
      tick(1'b0, 1'b0);
      for (int i = 0; i < 8; i++) tick(txb[i], rxb[i]);
      tick(1'b1, rxstop);
    end else begin
      tick(1'b0, lvl);
      for (int i = 0; i < 8; i++) tick(txb[i], lvl);
      tick(1'b1, lvl);
    end
    // nothing may show before field_end (R2)
    check({req, " R2 early"}, {bit_err, clamp_err, wake_err, abort_req},
          {m_flags[0], m_flags[1], m_flags[2], 1'b0});
    field_end = 1'b1; clr = clr_m;
    @(negedge clk);
    field_end = 1'b0; clr = 3'b000;
    tx_act  = (mode < 2);
    started = (stuck == 0);
    in_win  = started && (delay < int'(start_tmo));
    lvl_end = (stuck == 0) ? rxstop : lvl;
    clamp   = tx_act && !in_win;
    bad     = tx_act ? (started && ((rxb != txb) || !rxstop)) : (started && !rxstop);
    model_apply({1'b0, clamp, bad}, clr_m, code_for(clamp, bad, lvl_end));
    check({req, " R7 abort"}, {3'b000, abort_req}, {3'b000, clamp | bad});
    check({req, " flags"}, {1'b0, bit_err, clamp_err, wake_err}, {1'b0, m_flags[0], m_flags[1], m_flags[2]});
    check({req, " R9 code"}, err_code, m_code);
    hdr_tx = 1'b0; rsp_tx = 1'b0; rsp_rx = 1'b0; rx_bit = 1'b1; tx_bit = 1'b1;
    @(negedge clk);
    check({req, " R7 pulse"}, {3'b000, abort_req}, 4'b0000);
  endtask

  task automatic clear(input logic [2:0] mask, input string req);
    @(negedge clk);
    clr = mask;
    @(negedge clk);
    clr = 3'b000;
    model_apply(3'b000, mask, 4'b0000);
    check({req, " flags"}, {1'b0, bit_err, clamp_err, wake_err}, {1'b0, m_flags[0], m_flags[1], m_flags[2]});
    check({req, " code"}, err_code, m_code);
  endtask

  task automatic wake_pulse(input string req);
    @(negedge clk);
    rx_bit = 1'b0;
    @(negedge clk);
    model_apply(3'b100, 3'b000, 4'b0010);
    check({req, " wake"}, {3'b000, wake_err}, {3'b000, m_flags[2]});
    check({req, " code"}, err_code, m_code);
    rx_bit = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {bit_err, clamp_err, wake_err, abort_req}, 4'b0000);
    check("R10 code", err_code, 4'b0000);

    // R2 clean tx fields, then mismatch in header
    do_field(0, 8'h55, 8'h55, 1'b1, 0, 0, 3'b000, "R2 clean");
    do_field(1, 8'hA3, 8'hA3, 1'b1, 1, 0, 3'b000, "R2 clean rsp");
    do_field(0, 8'h55, 8'h57, 1'b1, 0, 0, 3'b000, "R2 mismatch");
    clear(3'b001, "R9 clear");
    do_field(1, 8'hF0, 8'hF0, 1'b0, 0, 0, 3'b000, "R2 stop mismatch");
    clear(3'b111, "R8 clear");

    // R3 receive: data differences ignored, dominant stop flagged
    do_field(2, 8'h00, 8'hC7, 1'b1, 0, 0, 3'b000, "R3 ignore data");
    do_field(2, 8'h00, 8'h3C, 1'b0, 0, 0, 3'b000, "R3 stop dominant");
    clear(3'b001, "R3 clear");

    // R4 stuck recessive, R5 stuck dominant
    do_field(0, 8'h55, 8'h55, 1'b1, 0, 1, 3'b000, "R4 stuck rec");
    clear(3'b111, "R4 clear");
    do_field(1, 8'h12, 8'h12, 1'b1, 0, 2, 3'b000, "R5 stuck dom");
    clear(3'b111, "R5 clear");
    do_field(2, 8'h12, 8'h12, 1'b1, 0, 2, 3'b000, "R5 rx mode no clamp");

    // window edges: start inside and just outside start_tmo
    start_tmo = 4'd4;
    do_field(0, 8'h81, 8'h81, 1'b1, 3, 0, 3'b000, "R4 late in window");
    start_tmo = 4'd2;
    do_field(0, 8'h81, 8'h81, 1'b1, 2, 0, 3'b000, "R4 start too late");
    clear(3'b111, "R4 clear2");

    // R6 late start plus mismatch
    do_field(1, 8'h0F, 8'h1F, 1'b1, 3, 0, 3'b000, "R6 both");
    // R8 set wins over clear in the same cycle; R9 code kept
    do_field(0, 8'h0F, 8'h0E, 1'b1, 0, 0, 3'b001, "R8 set wins");
    clear(3'b111, "R9 empty");

    // R1 wake from idle dominant, sticky with first code
    wake_pulse("R1 idle dominant");
    do_field(0, 8'h33, 8'h32, 1'b1, 0, 0, 3'b000, "R9 first code kept");
    clear(3'b100, "R9 partial clear");
    clear(3'b001, "R9 full clear");

    // random fields
    for (int k = 0; k < 80; k++) begin
      int mode, delay, stuck;
      logic [7:0] txb, rxb;
      logic stopb;
      mode  = int'($urandom_range(0, 2));
      txb   = 8'($urandom);
      rxb   = ($urandom_range(0, 3) == 0) ? (txb ^ (8'd1 << $urandom_range(0, 7))) : txb;
      stopb = ($urandom_range(0, 5) != 0);
      delay = int'($urandom_range(0, 3));
      stuck = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 2)) : 0;
      do_field(mode, txb, rxb, stopb, delay, stuck, 3'($urandom_range(0, 7)), "R2 random");
      if ($urandom_range(0, 9) == 0) wake_pulse("R1 random");
      if ($urandom_range(0, 4) == 0) clear(3'($urandom_range(0, 7)), "R8 random");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule